// File: doc/BRIEF.md
# Cascadable Dual 8-Bit Timer

This block holds two 8-bit up-counters. Each has two compare registers (A and B), two match flags, a counter-clear selection, interrupt enables and one waveform output. Software reaches all of this through a simple register port. A channel counts on an internal divided enable or on an external enable input, and it can be cleared on a compare match or by an external clear input.

A 3-bit clock-select code of 3'b100 joins the two channels. When channel 0 carries that code, the pair forms one 16-bit counter. Channel 0 is the upper byte and channel 1 is the lower byte. The lower byte runs on channel 1's own clock choice, and its wrap from 8'hFF to 8'h00 carries into the upper byte. When channel 1 carries the code, counter 1 counts channel 0's compare-match A events. When both carry it, nothing counts.

The joining is tracked by a four-state mode machine: INDEP, WIDE16, EVENT and FROZEN. Its next state is decoded from the two clock-select fields on every clock, and the register updates on the following edge. Any state can move directly to any other. The named transitions are:
- enter WIDE16 (only channel 0 selects 3'b100);
- enter EVENT (only channel 1 selects 3'b100);
- enter FROZEN (both select 3'b100);
- return to INDEP (neither selects 3'b100).

Top module: `dual_tmr8_cascade`

## Requirements
- R1: After reset, both counters read 0, both compare registers read 8'hFF, all flags, interrupts and waves are 0, and the mode is INDEP.
- R2: Register address = {channel, index}. Index 0 is control: [2:0] clock select, [4:3] clear select, [5] irq A enable, [6] irq B enable. Index 1 is output select. Index 2 is flags: [0] A, [1] B. Index 3 is the counter, index 4 compare A and index 5 compare B. Clock codes are: 000 stop, 001 every 8th clock, 010 every 64th, 011 every 8192nd, 101 each cycle ext_tick is high, 110 and 111 stop. A counter write overrides counting in the same cycle.
- R3: A match event of a source happens on a count pulse during which the counter equals that compare register. The clear select decides what that pulse does. With 01 (match A) or 10 (match B), the pulse loads 0 instead of incrementing. With 11, the counter is held at 0 while ext_clr is high. With 00, there is no clear.
- R4: A match event sets its flag. The flag stays set until software writes 0 to that bit after a read (rd_en) has returned it as 1. A write without such a read leaves the flag set. irq_a or irq_b is high while a flag and its enable are both 1.
- R5: Output select [1:0] acts on match A and [3:2] acts on match B. The codes are 00 keep, 01 low, 10 high, 11 toggle. When both events fire together, B's action is applied first and A's action is then applied to the result.
- R6: Channel 0 clock select 3'b100 (channel 1 not 3'b100) selects WIDE16. In WIDE16, counter 1 counts on channel 1's clock choice and counter 0 increments when counter 1 wraps from 8'hFF to 8'h00. Mode changes take effect from the second clock edge after the control write.
- R7: In WIDE16, channel 0's flags and wave respond to full 16-bit matches against {compare0, compare1}. Channel 1's flags and wave respond to lower-byte matches alone.
- R8: In WIDE16, channel 0's clear select governs both bytes. 01 clears both on a 16-bit A match and 10 clears both on a 16-bit B match. 11 clears both while ext_clr[0] is high and also on a 16-bit A match. Channel 1's clear select is ignored, so the lower byte is never cleared alone.
- R9: Channel 1 clock select 3'b100 (channel 0 not 3'b100) selects EVENT. In EVENT, counter 1 increments once per channel 0 match A event, and each channel applies its own flag, clear and output settings.
- R10: When both clock selects are 3'b100, the mode is FROZEN. No count pulses, match events or clears occur, and the counters change only by register writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 4 | Register address {channel, index} |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms flag clearing) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| ext_tick | input | 2 | Per-channel external count enable (clock code 101) |
| ext_clr | input | 2 | Per-channel external clear, level active |
| irq_a | output | 2 | Per-channel match A interrupt request |
| irq_b | output | 2 | Per-channel match B interrupt request |
| wave | output | 2 | Per-channel waveform output |

## Verification
The assertions assume that ext_clr and ext_tick are synchronous to clk and are driven only between clock edges. They also assume that counter registers are not written during the cycles being checked. The carry and lone-clear properties therefore exclude cycles with wr_en high, and the frozen-hold property only covers cycles without a write. The directed bench drives every input on the falling edge. It finishes all control writes and then waits two cycles before it drives count enables, so the mode register has settled before any count pulse is applied.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        M_INDEP  = 2'd0,
        M_WIDE16 = 2'd1,
        M_EVENT  = 2'd2,
        M_FROZEN = 2'd3
    } tmr_mode_e;

    localparam logic [2:0] CKS_STOP  = 3'b000;
    localparam logic [2:0] CKS_D8    = 3'b001;
    localparam logic [2:0] CKS_D64   = 3'b010;
    localparam logic [2:0] CKS_D8192 = 3'b011;
    localparam logic [2:0] CKS_JOIN  = 3'b100;
    localparam logic [2:0] CKS_EXT   = 3'b101;

    localparam logic [1:0] CLR_NONE = 2'b00;
    localparam logic [1:0] CLR_A    = 2'b01;
    localparam logic [1:0] CLR_B    = 2'b10;
    localparam logic [1:0] CLR_EXT  = 2'b11;

    localparam logic [1:0] OACT_KEEP = 2'b00;
    localparam logic [1:0] OACT_LOW  = 2'b01;
    localparam logic [1:0] OACT_HIGH = 2'b10;
    localparam logic [1:0] OACT_TOG  = 2'b11;

    localparam logic [2:0] RG_CTL  = 3'd0;
    localparam logic [2:0] RG_OSEL = 3'd1;
    localparam logic [2:0] RG_FLG  = 3'd2;
    localparam logic [2:0] RG_CNT  = 3'd3;
    localparam logic [2:0] RG_CMPA = 3'd4;
    localparam logic [2:0] RG_CMPB = 3'd5;

    typedef struct packed {
        logic       ie_b;
        logic       ie_a;
        logic [1:0] clr;
        logic [2:0] cks;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    function automatic logic apply_oact(input logic [1:0] act, input logic cur);
        case (act)
            OACT_LOW:  apply_oact = 1'b0;
            OACT_HIGH: apply_oact = 1'b1;
            OACT_TOG:  apply_oact = ~cur;
            default:   apply_oact = cur;
        endcase
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int LOG_A = 3,
    parameter int LOG_B = 6,
    parameter int LOG_C = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [2:0] tick
);
    localparam int PW = (LOG_C > LOG_B) ? ((LOG_C > LOG_A) ? LOG_C : LOG_A)
                                        : ((LOG_B > LOG_A) ? LOG_B : LOG_A);

    logic [PW-1:0] ps_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_q + 1'b1;
    end

    // A tap fires on the single cycle of each period where its low bits are all ones
    assign tick[0] = &ps_q[LOG_A-1:0];
    assign tick[1] = &ps_q[LOG_B-1:0];
    assign tick[2] = &ps_q[LOG_C-1:0];
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [2:0]    idx,
    input  logic [DW-1:0] wdata,
    input  logic          inc,
    input  logic          clr,
    input  logic          evt_a,
    input  logic          evt_b,
    output ctl_t          ctl,
    output logic [DW-1:0] cnt,
    output logic [DW-1:0] cmpa,
    output logic [DW-1:0] cmpb,
    output logic [DW-1:0] rdata,
    output logic          irq_a,
    output logic          irq_b,
    output logic          wave
);
    logic       we;
    ctl_t       ctl_q;
    logic [3:0] osel_q;
    logic [1:0] flg_q, arm_q, flg_nx;
    logic [DW-1:0] cnt_q, cmpa_q, cmpb_q;
    logic       wave_q, wave_nx;

    assign we = wr_en && sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            osel_q <= '0;
            cmpa_q <= '1;
            cmpb_q <= '1;
        end else if (we) begin
            if (idx == RG_CTL)  ctl_q  <= ctl_t'(wdata[CTL_W-1:0]);
            if (idx == RG_OSEL) osel_q <= wdata[3:0];
            if (idx == RG_CMPA) cmpa_q <= wdata;
            if (idx == RG_CMPB) cmpb_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (we && idx == RG_CNT)  cnt_q <= wdata;
        else if (clr)                  cnt_q <= '0;
        else if (inc)                  cnt_q <= cnt_q + 1'b1;
    end

    // Flag clearing needs a prior read that saw the bit set; setting wins
    always_comb begin
        flg_nx = flg_q;
        if (we && idx == RG_FLG) flg_nx = flg_q & ~(arm_q & ~wdata[1:0]);
        flg_nx = flg_nx | {evt_b, evt_a};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flg_q <= '0;
            arm_q <= '0;
        end else begin
            flg_q <= flg_nx;
            if (we && idx == RG_FLG)               arm_q <= '0;
            else if (rd_en && sel && idx == RG_FLG) arm_q <= flg_q;
        end
    end

    always_comb begin
        wave_nx = wave_q;
        if (evt_b) wave_nx = apply_oact(osel_q[3:2], wave_nx);
        if (evt_a) wave_nx = apply_oact(osel_q[1:0], wave_nx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wave_q <= 1'b0;
        else        wave_q <= wave_nx;
    end

    always_comb begin
        rdata = '0;
        case (idx)
            RG_CTL:  rdata[CTL_W-1:0] = ctl_q;
            RG_OSEL: rdata[3:0] = osel_q;
            RG_FLG:  rdata[1:0] = flg_q;
            RG_CNT:  rdata = cnt_q;
            RG_CMPA: rdata = cmpa_q;
            RG_CMPB: rdata = cmpb_q;
            default: rdata = '0;
        endcase
    end

    assign ctl   = ctl_q;
    assign cnt   = cnt_q;
    assign cmpa  = cmpa_q;
    assign cmpb  = cmpb_q;
    assign irq_a = flg_q[0] && ctl_q.ie_a;
    assign irq_b = flg_q[1] && ctl_q.ie_b;
    assign wave  = wave_q;

    a_r4_flag_a_set: assert property (@(posedge clk) disable iff (!rst_n)
        evt_a |=> flg_q[0]);
    a_r4_flag_b_set: assert property (@(posedge clk) disable iff (!rst_n)
        evt_b |=> flg_q[1]);
    a_r5_a_high_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_a && osel_q[1:0] == OACT_HIGH) |=> wave_q);
    a_r5_a_low_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_a && osel_q[1:0] == OACT_LOW) |=> !wave_q);
endmodule

// File: rtl/tmr_cascade_ctl.sv
module tmr_cascade_ctl
    import tmr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctl_t          ctl0,
    input  ctl_t          ctl1,
    input  logic [2:0]    tick,
    input  logic [1:0]    ext_tick,
    input  logic [1:0]    ext_clr,
    input  logic [DW-1:0] cnt0,
    input  logic [DW-1:0] cnt1,
    input  logic [DW-1:0] cmpa0,
    input  logic [DW-1:0] cmpb0,
    input  logic [DW-1:0] cmpa1,
    input  logic [DW-1:0] cmpb1,
    output tmr_mode_e     mode,
    output logic [1:0]    inc,
    output logic [1:0]    clr,
    output logic [1:0]    evt_a,
    output logic [1:0]    evt_b
);
    tmr_mode_e mode_q, mode_nx;
    logic p0, p1, lo_a, lo_b, full_a, full_b, clr16;

    function automatic logic own_pulse(input logic [2:0] cks, input logic [2:0] tk,
                                       input logic ext);
        case (cks)
            CKS_D8:    own_pulse = tk[0];
            CKS_D64:   own_pulse = tk[1];
            CKS_D8192: own_pulse = tk[2];
            CKS_EXT:   own_pulse = ext;
            default:   own_pulse = 1'b0;
        endcase
    endfunction

    function automatic logic own_clear(input logic [1:0] cs, input logic ea,
                                       input logic eb, input logic xc);
        own_clear = (cs == CLR_A && ea) || (cs == CLR_B && eb) || (cs == CLR_EXT && xc);
    endfunction

    always_comb begin
        unique case ({ctl0.cks == CKS_JOIN, ctl1.cks == CKS_JOIN})
            2'b00: mode_nx = M_INDEP;
            2'b10: mode_nx = M_WIDE16;
            2'b01: mode_nx = M_EVENT;
            2'b11: mode_nx = M_FROZEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= M_INDEP;
        else        mode_q <= mode_nx;
    end

    assign p0     = own_pulse(ctl0.cks, tick, ext_tick[0]);
    assign p1     = own_pulse(ctl1.cks, tick, ext_tick[1]);
    assign lo_a   = (cnt1 == cmpa1);
    assign lo_b   = (cnt1 == cmpb1);
    assign full_a = ({cnt0, cnt1} == {cmpa0, cmpa1});
    assign full_b = ({cnt0, cnt1} == {cmpb0, cmpb1});

    always_comb begin
        inc   = '0;
        clr   = '0;
        evt_a = '0;
        evt_b = '0;
        clr16 = 1'b0;
        unique case (mode_q)
            M_INDEP: begin
                inc      = {p1, p0};
                evt_a[0] = p0 && (cnt0 == cmpa0);
                evt_b[0] = p0 && (cnt0 == cmpb0);
                evt_a[1] = p1 && lo_a;
                evt_b[1] = p1 && lo_b;
                clr[0]   = own_clear(ctl0.clr, evt_a[0], evt_b[0], ext_clr[0]);
                clr[1]   = own_clear(ctl1.clr, evt_a[1], evt_b[1], ext_clr[1]);
            end
            M_EVENT: begin
                inc[0]   = p0;
                evt_a[0] = p0 && (cnt0 == cmpa0);
                evt_b[0] = p0 && (cnt0 == cmpb0);
                inc[1]   = evt_a[0];
                evt_a[1] = evt_a[0] && lo_a;
                evt_b[1] = evt_a[0] && lo_b;
                clr[0]   = own_clear(ctl0.clr, evt_a[0], evt_b[0], ext_clr[0]);
                clr[1]   = own_clear(ctl1.clr, evt_a[1], evt_b[1], ext_clr[1]);
            end
            M_WIDE16: begin
                inc[1]   = p1;
                inc[0]   = p1 && (cnt1 == '1);
                evt_a[0] = p1 && full_a;
                evt_b[0] = p1 && full_b;
                evt_a[1] = p1 && lo_a;
                evt_b[1] = p1 && lo_b;
                // external-clear selection still clears on a full A match
                clr16    = own_clear(ctl0.clr, evt_a[0], evt_b[0], ext_clr[0])
                        || (ctl0.clr == CLR_EXT && evt_a[0]);
                clr      = {clr16, clr16};
            end
            M_FROZEN: begin
                inc = '0;
            end
        endcase
    end

    assign mode = mode_q;

    a_r10_both_join_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl0.cks == CKS_JOIN && ctl1.cks == CKS_JOIN) |=> (mode_q == M_FROZEN));
    a_r6_join0_wide: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl0.cks == CKS_JOIN && ctl1.cks != CKS_JOIN) |=> (mode_q == M_WIDE16));
    a_r9_join1_event: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl0.cks != CKS_JOIN && ctl1.cks == CKS_JOIN) |=> (mode_q == M_EVENT));
endmodule

// File: rtl/dual_tmr8_cascade.sv
module dual_tmr8_cascade
    import tmr_pkg::*;
#(
    parameter int DW    = 8,
    parameter int LOG_A = 3,
    parameter int LOG_B = 6,
    parameter int LOG_C = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [1:0]    ext_tick,
    input  logic [1:0]    ext_clr,
    output logic [1:0]    irq_a,
    output logic [1:0]    irq_b,
    output logic [1:0]    wave
);
    localparam int NCH = 2;

    logic [2:0]              tick;
    ctl_t                    ctl_w  [NCH];
    logic [NCH-1:0][DW-1:0]  cnt_w, cmpa_w, cmpb_w, rd_w;
    logic [NCH-1:0]          inc_w, clr_w, evta_w, evtb_w;
    tmr_mode_e               mode_w;

    tmr_prescaler #(.LOG_A(LOG_A), .LOG_B(LOG_B), .LOG_C(LOG_C)) u_ps (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    for (genvar gc = 0; gc < NCH; gc++) begin : g_ch
        tmr_channel #(.DW(DW)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .sel(addr[3] == gc[0]), .wr_en(wr_en), .rd_en(rd_en),
            .idx(addr[2:0]), .wdata(wdata),
            .inc(inc_w[gc]), .clr(clr_w[gc]), .evt_a(evta_w[gc]), .evt_b(evtb_w[gc]),
            .ctl(ctl_w[gc]), .cnt(cnt_w[gc]), .cmpa(cmpa_w[gc]), .cmpb(cmpb_w[gc]),
            .rdata(rd_w[gc]), .irq_a(irq_a[gc]), .irq_b(irq_b[gc]), .wave(wave[gc])
        );
    end

    tmr_cascade_ctl #(.DW(DW)) u_mode (
        .clk(clk), .rst_n(rst_n), .ctl0(ctl_w[0]), .ctl1(ctl_w[1]),
        .tick(tick), .ext_tick(ext_tick), .ext_clr(ext_clr),
        .cnt0(cnt_w[0]), .cnt1(cnt_w[1]),
        .cmpa0(cmpa_w[0]), .cmpb0(cmpb_w[0]), .cmpa1(cmpa_w[1]), .cmpb1(cmpb_w[1]),
        .mode(mode_w), .inc(inc_w), .clr(clr_w), .evt_a(evta_w), .evt_b(evtb_w)
    );

    assign rdata = rd_w[addr[3]];

    a_r10_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == M_FROZEN && !wr_en) |=> ($stable(cnt_w[0]) && $stable(cnt_w[1])));
    a_r8_no_lone_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == M_WIDE16 && !wr_en && cnt_w[1] != '0 && cnt_w[1] != '1)
        |=> (cnt_w[1] != '0 || cnt_w[0] == '0));
    a_r6_carry_up: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == M_WIDE16 && !wr_en && cnt_w[1] == '1 && cnt_w[0] != '1)
        |=> (cnt_w[1] == '1) ||
            (cnt_w[1] == '0 && (cnt_w[0] == '0 || cnt_w[0] == $past(cnt_w[0]) + 1'b1)));
endmodule

// File: tb/dual_tmr8_cascade_test.sv
module dual_tmr8_cascade_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] ext_tick = '0, ext_clr = '0;
    logic [1:0] irq_a, irq_b, wave;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_tmr8_cascade uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .ext_tick(ext_tick), .ext_clr(ext_clr),
        .irq_a(irq_a), .irq_b(irq_b), .wave(wave)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ext_tick = '0;
        ext_clr = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [1:0] m, input int n);
        @(negedge clk);
        ext_tick = m;
        repeat (n) @(negedge clk);
        ext_tick = '0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset();
        rd(4'h3, v); chk("R1 cnt0", v, 8'h00);
        rd(4'hB, v); chk("R1 cnt1", v, 8'h00);
        rd(4'h4, v); chk("R1 cmpa0", v, 8'hFF);
        rd(4'h2, v); chk("R1 flg0", v, 8'h00);
        chk("R1 outs", {irq_a, irq_b, wave}, 6'b0);
    endtask

    task automatic t_indep();
        logic [7:0] v;
        do_reset();
        wr(4'h0, 8'h2D);   // ext enable, clear on A, irq A enabled
        wr(4'h4, 8'h05);
        wr(4'h1, 8'h03);   // toggle on A
        pulse(2'b01, 6);
        rd(4'h3, v); chk("R3 clear on A", v, 8'h00);
        chk("R5 toggle", wave[0], 1'b1);
        chk("R4 irq_a", irq_a[0], 1'b1);
        wr(4'h2, 8'h00);
        rd(4'h2, v); chk("R4 write without read keeps flag", v, 8'h01);
        wr(4'h2, 8'h00);
        rd(4'h2, v); chk("R4 flag cleared", v, 8'h00);
        chk("R4 irq dropped", irq_a[0], 1'b0);
        pulse(2'b01, 3);
        rd(4'h3, v); chk("R2 ext enable count", v, 8'h03);
        // channel 1: clear on B, toggle on B
        wr(4'hD, 8'h02);
        wr(4'h8, 8'h15);
        wr(4'h9, 8'h0C);
        pulse(2'b10, 3);
        rd(4'hB, v); chk("R3 clear on B", v, 8'h00);
        rd(4'hA, v); chk("R4 flag B", v, 8'h02);
        chk("R5 toggle on B", wave[1], 1'b1);
        // external clear
        wr(4'h8, 8'h1D);
        wr(4'hB, 8'h40);
        @(negedge clk); ext_clr = 2'b10; @(negedge clk); ext_clr = 2'b00;
        rd(4'hB, v); chk("R3 ext clear", v, 8'h00);
    endtask

    task automatic t_order();
        logic [7:0] v;
        do_reset();
        wr(4'h0, 8'h05);
        wr(4'h4, 8'h02);
        wr(4'h5, 8'h02);
        wr(4'h1, 8'h09);   // A low, B high
        pulse(2'b01, 3);
        chk("R5 A after B (low)", wave[0], 1'b0);
        rd(4'h2, v); chk("R4 both flags", v, 8'h03);
        wr(4'h1, 8'h06);   // A high, B low
        wr(4'h3, 8'h02);
        pulse(2'b01, 1);
        chk("R5 A after B (high)", wave[0], 1'b1);
    endtask

    task automatic t_div();
        logic [7:0] v, w;
        do_reset();
        wr(4'h8, 8'h01);
        wr(4'hB, 8'h00);
        repeat (64) @(posedge clk);
        @(negedge clk);
        #1 addr = 4'hB;
        #1 chk("R2 divide by 8", rdata, 8'h08);
        wr(4'h8, 8'h00);
        rd(4'hB, v);
        repeat (40) @(negedge clk);
        rd(4'hB, w);
        chk("R2 stop code", w, v);
    endtask

    task automatic t_wide();
        logic [7:0] v;
        do_reset();
        wr(4'h8, 8'h05);
        wr(4'h4, 8'h01); wr(4'hC, 8'h02);
        wr(4'h5, 8'h80); wr(4'hD, 8'h80);
        wr(4'hB, 8'hFE);
        wr(4'h0, 8'h0C);   // join, clear on A
        settle();
        pulse(2'b10, 2);
        rd(4'h3, v); chk("R6 carry upper", v, 8'h01);
        rd(4'hB, v); chk("R6 lower wrapped", v, 8'h00);
        pulse(2'b10, 3);
        rd(4'h3, v); chk("R8 16-bit clear upper", v, 8'h00);
        rd(4'hB, v); chk("R8 16-bit clear lower", v, 8'h00);
        rd(4'h2, v); chk("R7 full match flag", v, 8'h01);
        rd(4'hA, v); chk("R7 low match flag", v, 8'h01);
        wr(4'h2, 8'h00); wr(4'hA, 8'h00);
        wr(4'h4, 8'h03);
        wr(4'h8, 8'h0D);   // ch1 clear-on-A, must be ignored
        wr(4'h9, 8'h02);   // ch1 high on A
        settle();
        pulse(2'b10, 3);
        rd(4'hB, v); chk("R8 lower clear ignored", v, 8'h03);
        rd(4'hA, v); chk("R7 low flag again", v, 8'h01);
        rd(4'h2, v); chk("R7 no full flag", v, 8'h00);
        chk("R7 wave1 on low match", wave, 2'b10);
        wr(4'h0, 8'h1C);   // join, external clear
        @(negedge clk); ext_clr = 2'b01; @(negedge clk); ext_clr = 2'b00;
        rd(4'hB, v); chk("R8 ext clear both", v, 8'h00);
    endtask

    task automatic t_event();
        logic [7:0] v;
        do_reset();
        wr(4'h0, 8'h0D);
        wr(4'h4, 8'h01);
        wr(4'h8, 8'h0C);   // join on ch1, own clear on A
        wr(4'hC, 8'h03);
        settle();
        pulse(2'b01, 6);
        rd(4'hB, v); chk("R9 counts ch0 matches", v, 8'h03);
        rd(4'h3, v); chk("R9 ch0 own clear", v, 8'h00);
        pulse(2'b01, 2);
        rd(4'hB, v); chk("R9 ch1 own clear", v, 8'h00);
        rd(4'hA, v); chk("R9 ch1 own flag", v, 8'h01);
    endtask

    task automatic t_frozen();
        logic [7:0] v;
        do_reset();
        wr(4'h3, 8'h10); wr(4'hB, 8'h20);
        wr(4'h0, 8'h04); wr(4'h8, 8'h04);
        settle();
        pulse(2'b11, 5);
        @(negedge clk); ext_clr = 2'b11; @(negedge clk); ext_clr = 2'b00;
        rd(4'h3, v); chk("R10 cnt0 frozen", v, 8'h10);
        rd(4'hB, v); chk("R10 cnt1 frozen", v, 8'h20);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        t_reset();
        t_indep();
        t_order();
        t_div();
        t_wide();
        t_event();
        t_frozen();
        summary();
    end
endmodule